// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control register file of an audio codec. A bus master reaches it through a 32-bit synchronous slave port with separate read and write strobes and a 6-bit byte address. Sixteen 32-bit word registers are mapped directly. Word 1 is not storage. It is a data window onto a bank of thirty-two 8-bit registers, and the index into that bank is the low five bits of word 0.

Several slots follow their own access rules. One banked slot is write-only and always reads zero. Two banked slots are read-only, and one of them holds a fixed identity code. A third banked slot keeps one writable flag beside a fixed version code. Word 2 ignores writes. Word 4 is the control word: a write with bit 0 set returns the whole block to its power-up contents, and word 4 then keeps the written value truncated to 7 bits.

Top module: `codec_ctrl_regs`

## Requirements
- R1: The word register is selected by address bits [5:2], and bits [1:0] are ignored. Words 0, 3 and 5 to 15 store and return all 32 bits of write data.
- R2: Read data is registered. It shows the addressed value on the clock after `rd_en` is sampled high and holds that value while `rd_en` stays low.
- R3: A read or write at word 1 goes to the banked register chosen by the current index. A write stores `wdata[7:0]`, and a read returns the stored byte in bits [7:0] with zeros above.
- R4: A read of bank slot 3 returns 0 whatever was written to it.
- R5: Writes to bank slots 11 and 25 are ignored. Slot 25 always reads 0xA0 and slot 11 reads 0 after reset.
- R6: A write to bank slot 12 stores `(wdata[7:0] & 0x40) | 0x8A`.
- R7: Writes to word 2 are ignored, and word 2 always reads 0.
- R8: A write to word 4 stores `wdata & 0x7F`.
- R9: A write to word 4 with `wdata[0]`=1 restores every register to its reset value in the same clock, and then word 4 keeps `wdata & 0x7F`.
- R10: After `rst`, every word reads 0, `rdata` is 0, bank slot 12 holds 0x8A, slot 25 holds 0xA0, and all other bank slots hold 0.
- R11: Word 0 stores all 32 bits, but only bits [4:0] form the bank index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe (never high in the same cycle as wr_en) |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The assertions run on every cycle and check the following: the hold behaviour of the read register, the forced zero for slot 3 and word 2, the byte returned through the window, the constant identity slot, the fixed bits of the version slot, the 7-bit mask on the control word, and the clearing effect of a software reset. Other behaviours are shown only by the bench scenarios: that bits [1:0] of the address are ignored, that writes to the read-only slots leave no trace, that only the low five bits of word 0 steer the window, and that every word and slot returns to its reset value after a software reset.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int DIR_CNT = 16;
  localparam int DIR_W   = 32;
  localparam int IND_CNT = 32;
  localparam int IND_W   = 8;
  localparam int ADDR_W  = 6;

  localparam int WIN_SLOT  = 1;
  localparam int LOCK_SLOT = 2;
  localparam int CTRL_SLOT = 4;

  localparam int IND_WO   = 3;
  localparam int IND_RO   = 11;
  localparam int IND_VER  = 12;
  localparam int IND_ID   = 25;

  localparam logic [7:0]  VER_CODE  = 8'h8A;
  localparam logic [7:0]  ID_CODE   = 8'hA0;
  localparam logic [7:0]  VER_KEEP  = 8'h40;
  localparam logic [31:0] CTRL_MASK = 32'h0000_007F;
endpackage

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_regs_pkg::*;
#(
  parameter int N  = DIR_CNT,
  parameter int W  = DIR_W,
  localparam int SW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [SW-1:0]     sel,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_word
    if (i == WIN_SLOT || i == LOCK_SLOT) begin : g_none
      assign q[i] = '0;
    end else if (i == CTRL_SLOT) begin : g_ctrl
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)                         r <= '0;
        else if (we && sel == SW'(i))    r <= wdata & W'(CTRL_MASK);
        else if (clr)                    r <= '0;
      end
      assign q[i] = r;
    end else begin : g_plain
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst || clr)                  r <= '0;
        else if (we && sel == SW'(i))    r <= wdata;
      end
      assign q[i] = r;
    end
  end
endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
  import codec_regs_pkg::*;
#(
  parameter int N  = IND_CNT,
  parameter int W  = IND_W,
  localparam int XW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [XW-1:0]     idx,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam logic [W-1:0] RV = (i == IND_VER) ? W'(VER_CODE) :
                                  (i == IND_ID)  ? W'(ID_CODE)  : '0;
    logic [W-1:0] r;
    if (i == IND_RO || i == IND_ID) begin : g_ro
      always_ff @(posedge clk) begin
        if (rst || clr) r <= RV;
      end
    end else if (i == IND_VER) begin : g_ver
      always_ff @(posedge clk) begin
        if (rst || clr)                  r <= RV;
        else if (we && idx == XW'(i))    r <= (wdata & W'(VER_KEEP)) | W'(VER_CODE);
      end
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (rst || clr)                  r <= RV;
        else if (we && idx == XW'(i))    r <= wdata;
      end
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_regs_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DN  = DIR_CNT,
  parameter int DW  = DIR_W,
  parameter int IN  = IND_CNT,
  parameter int IW  = IND_W,
  localparam int SW = $clog2(DN),
  localparam int XW = $clog2(IN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [SW-1:0]          word;
  logic [DN-1:0][DW-1:0]  dir_q;
  logic [IN-1:0][IW-1:0]  ind_q;
  logic [XW-1:0]          ind_idx;
  logic                   soft_clr;
  logic                   win_hit;
  logic [DW-1:0]          rd_val;

  assign word     = addr[SW+1:2];
  assign ind_idx  = dir_q[0][XW-1:0];
  assign win_hit  = (word == SW'(WIN_SLOT));
  assign soft_clr = wr_en && (word == SW'(CTRL_SLOT)) && wdata[0];

  codec_direct_bank #(.N(DN), .W(DW)) u_dir (
    .clk(clk), .rst(rst), .clr(soft_clr), .we(wr_en),
    .sel(word), .wdata(wdata), .q(dir_q)
  );

  codec_indirect_bank #(.N(IN), .W(IW)) u_ind (
    .clk(clk), .rst(rst), .clr(soft_clr), .we(wr_en && win_hit),
    .idx(ind_idx), .wdata(wdata[IW-1:0]), .q(ind_q)
  );

  always_comb begin
    if (!win_hit)                     rd_val = dir_q[word];
    else if (ind_idx == XW'(IND_WO))  rd_val = '0;
    else                              rd_val = {{(DW-IW){1'b0}}, ind_q[ind_idx]};
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/codec_ctrl_regs_chk.sv
module codec_ctrl_regs_chk
  import codec_regs_pkg::*;
(
  input logic                          clk,
  input logic                          rst,
  input logic                          rd_en,
  input logic                          wr_en,
  input logic [5:0]                    addr,
  input logic [31:0]                   wdata,
  input logic [31:0]                   rdata,
  input logic [4:0]                    idx,
  input logic [DIR_CNT-1:0][DIR_W-1:0] dir_q,
  input logic [IND_CNT-1:0][IND_W-1:0] ind_q
);
  logic [3:0] word;
  assign word = addr[5:2];

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_en) && !$past(rst)) |-> $stable(rdata));

  // R3
  window_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && word == 4'(WIN_SLOT) && idx != 5'(IND_WO)) |=> rdata == {24'b0, $past(ind_q[idx])});

  // R4
  wo_slot_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && word == 4'(WIN_SLOT) && idx == 5'(IND_WO)) |=> rdata == 32'b0);

  // R5
  id_const_chk: assert property (@(posedge clk) disable iff (rst)
    ind_q[IND_ID] == ID_CODE);

  // R6
  ver_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (ind_q[IND_VER] & ~VER_KEEP) == VER_CODE);

  // R7
  lock_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && word == 4'(LOCK_SLOT)) |=> rdata == 32'b0);

  // R8
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && word == 4'(CTRL_SLOT)) |=> dir_q[CTRL_SLOT] == ($past(wdata) & CTRL_MASK));

  // R9
  soft_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && word == 4'(CTRL_SLOT) && wdata[0]) |=> (dir_q[0] == 32'b0 && ind_q[IND_VER] == VER_CODE));
endmodule

bind codec_ctrl_regs codec_ctrl_regs_chk u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .idx(ind_idx), .dir_q(dir_q), .ind_q(ind_q)
);

// File: tb/codec_ctrl_regs_tb.sv
module codec_ctrl_regs_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        rd_en = 0;
  logic        wr_en = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 0;
  logic [31:0] held;

  always #10 clk = ~clk;

  codec_ctrl_regs u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always @(posedge clk) pend <= rd_en && !rst;

  // monitor: compares each registered result against the scoreboard
  always @(negedge clk) begin
    if (pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] e, input string t);
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", t, act, e);
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rdata, 32'h0, "R10 rdata after reset");
    rst = 0;

    // R10 reset contents
    rd(6'h00, 32'h0, "R10 word0");
    rd(6'h3C, 32'h0, "R10 word15");
    wr(6'h00, 32'd12);
    rd(6'h04, 32'h8A, "R10 slot12");
    wr(6'h00, 32'd25);
    rd(6'h04, 32'hA0, "R10 slot25");
    wr(6'h00, 32'd5);
    rd(6'h04, 32'h0, "R10 slot5");

    // R1 decode and full-width storage
    wr(6'h1C, 32'hDEADBEEF);
    rd(6'h1C, 32'hDEADBEEF, "R1 word7");
    wr(6'h3F, 32'h12345678);
    rd(6'h3C, 32'h12345678, "R1 word15 low addr bits ignored");
    rd(6'h1E, 32'hDEADBEEF, "R1 word7 alias");

    // R2 hold while rd_en low
    @(negedge clk); held = rdata;
    addr = 6'h3C;
    repeat (3) @(negedge clk);
    check(rdata, held, "R2 hold");

    // R11 index from bits [4:0]; R3 window byte
    wr(6'h00, 32'hFFFF_FF47);
    rd(6'h00, 32'hFFFF_FF47, "R11 word0 full width");
    wr(6'h04, 32'hABCD_1234);
    rd(6'h04, 32'h0000_0034, "R3 window byte zero-extended");
    wr(6'h00, 32'h0000_0007);
    rd(6'h04, 32'h0000_0034, "R11 same slot via index 7");

    // R4 write-only slot
    wr(6'h00, 32'd3);
    wr(6'h04, 32'h55);
    rd(6'h04, 32'h0, "R4 slot3 reads zero");

    // R5 read-only slots
    wr(6'h00, 32'd11);
    wr(6'h04, 32'h77);
    rd(6'h04, 32'h0, "R5 slot11 ignored");
    wr(6'h00, 32'd25);
    wr(6'h04, 32'h11);
    rd(6'h04, 32'hA0, "R5 slot25 ignored");

    // R6 version slot
    wr(6'h00, 32'd12);
    wr(6'h04, 32'hFF);
    rd(6'h04, 32'hCA, "R6 slot12 all ones");
    wr(6'h04, 32'h00);
    rd(6'h04, 32'h8A, "R6 slot12 zero");
    wr(6'h04, 32'h40);
    rd(6'h04, 32'hCA, "R6 slot12 flag");

    // R7 locked word
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, 32'h0, "R7 word2");

    // R8 control mask without reset bit
    wr(6'h10, 32'hFFFF_FFFE);
    rd(6'h10, 32'h7E, "R8 word4 mask");
    rd(6'h1C, 32'hDEADBEEF, "R8 no clear without bit0");

    // R9 software reset
    wr(6'h10, 32'h0000_0183);
    rd(6'h10, 32'h03, "R9 word4 keeps masked value");
    rd(6'h1C, 32'h0, "R9 word7 cleared");
    rd(6'h3C, 32'h0, "R9 word15 cleared");
    rd(6'h00, 32'h0, "R9 word0 cleared");
    rd(6'h04, 32'h0, "R9 slot0 via cleared index");
    wr(6'h00, 32'd12);
    rd(6'h04, 32'h8A, "R9 slot12 restored");
    wr(6'h00, 32'd7);
    rd(6'h04, 32'h0, "R9 slot7 cleared");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule